// File: doc/BRIEF.md
# Latency-Aware Stream Port Buffer

This block is the endpoint of a flow-controlled channel joining a compute region that runs on a fixed schedule to a dynamic channel between regions. It holds a small FIFO. In send mode the region pushes words into it through predicated writes, and the block drives them outward on a valid/ready channel. In receive mode the block accepts words from the channel and hands them to predicated reads from the region.

A region may take L cycles to freeze once a stall is requested. For that reason the port asks for a stall early. It predicts whether the buffer could overflow (send) or run dry (receive) within that window. It can use one of three predictors: a fixed margin equal to L, a programmed worst-case access count, or an exact count of pending accesses announced L cycles in advance. The port itself never freezes. It keeps moving words on the channel, so its stall request clears on its own. A non-blocking read option never stalls and returns a presence flag with the word.

Top module: `stream_port_buf`

## Requirements
- R1: After reset the buffer is empty, `ch_out_valid` and `rd_hit` are 0, and the pending count is 0.
- R2: In send mode (`cfg_recv`=0), a write with `acc_pred`=1 stores `acc_wdata` when the buffer is not full. `ch_out_valid` is 1 whenever the buffer holds a word, and `ch_out_data` shows the oldest word. A word leaves the buffer in a cycle where `ch_in_ready` is 1, and words leave in write order.
- R3: In receive mode (`cfg_recv`=1), `ch_out_ready` is 1 whenever the buffer is not full, and a word is taken when `ch_in_valid` is also 1. `rd_data` shows the oldest word, and a read with `acc_pred`=1 removes it. Words are read in arrival order.
- R4: When a push and a pop happen in the same cycle, the occupancy is unchanged.
- R5: `stall_req` is 0 in any cycle where `acc_pred` is 0.
- R6: With `cfg_mode`=0 (latency mode; code 3 acts the same way), an access stalls when M <= `cfg_lat`. M is the free space in send mode and the held word count in receive mode.
- R7: With `cfg_mode`=1 (estimate mode), an access stalls when M <= `cfg_rate`.
- R8: With `cfg_mode`=2 (precheck mode), `pre_pred` raises a pending count by one and an access lowers it by one. The count saturates at 0 and at 63. An access stalls when the count plus `pre_pred` exceeds M.
- R9: In receive mode with `cfg_nonblock`=1, `stall_req` is always 0. `rd_hit` is 1 exactly when a word is held, and `rd_data` is 0 when nothing is held.
- R10: A write to a full buffer is discarded, and a read from an empty buffer removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_recv | input | 1 | 0 send mode, 1 receive mode |
| cfg_mode | input | 2 | Predictor: 0 latency, 1 estimate, 2 precheck |
| cfg_lat | input | 4 | Stall latency L (0 to 9) |
| cfg_rate | input | 5 | Worst-case access count within L cycles |
| cfg_nonblock | input | 1 | Non-blocking reads (receive mode) |
| acc_pred | input | 1 | Scheduled access is active |
| acc_wdata | input | 32 | Write word from region |
| pre_pred | input | 1 | Access announced L cycles ahead |
| rd_data | output | 32 | Oldest held word (receive mode) |
| rd_hit | output | 1 | A word is held for reading |
| stall_req | output | 1 | Early stall request to the region |
| ch_out_valid | output | 1 | Send mode: word present on channel |
| ch_out_data | output | 32 | Send mode: channel word |
| ch_in_ready | input | 1 | Send mode: far end accepts |
| ch_in_valid | input | 1 | Receive mode: far end offers a word |
| ch_in_data | input | 32 | Receive mode: offered word |
| ch_out_ready | output | 1 | Receive mode: room for a word |

## Verification
`stall_req`, `rd_data`, `rd_hit`, `ch_out_valid`, `ch_out_data` and `ch_out_ready` are combinational from registered state and the current inputs, so each is due in the same cycle as its stimulus. Each push, pop or pending-count change shows up in those outputs one clock edge later. The bench drives inputs on the falling edge and samples shortly after. It then advances its own occupancy, queue and pending model as the next rising edge will. Every comparison therefore sees state from exactly the edges that came before it.

// File: rtl/spb_pkg.sv
package spb_pkg;
    typedef enum logic [1:0] {
        PM_LATENCY  = 2'd0,
        PM_ESTIMATE = 2'd1,
        PM_PRECHECK = 2'd2,
        PM_SPARE    = 2'd3
    } pred_mode_e;
endpackage

// File: rtl/spb_store.sv
module spb_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } st_t;

    st_t           s_q, s_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        do_push = push && (s_q.cnt != CW'(DEPTH));
        do_pop  = pop && (s_q.cnt != '0);
        s_d     = s_q;
        if (do_push) s_d.wr = bump(s_q.wr);
        if (do_pop)  s_d.rd = bump(s_q.rd);
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + CW'(1);
            2'b01:   s_d.cnt = s_q.cnt - CW'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wr] <= wdata;
    end

    assign head  = mem_q[s_q.rd];
    assign count = s_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH)); // R10
    AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && do_pop) |=> (s_q.cnt == $past(s_q.cnt))); // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && s_q.cnt == CW'(DEPTH)) |=> (s_q.cnt == CW'(DEPTH))); // R10
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && s_q.cnt == '0) |=> (s_q.cnt == '0)); // R10
endmodule

// File: rtl/spb_predict.sv
module spb_predict
    import spb_pkg::*;
#(
    parameter int CW = 5,
    parameter int LW = 4,
    parameter int RW = 5,
    parameter int PW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pred_mode_e    mode,
    input  logic [LW-1:0] lat,
    input  logic [RW-1:0] rate,
    input  logic [CW-1:0] metric,
    input  logic          pre_pred,
    input  logic          acc_pred,
    input  logic          quiet,
    output logic          stall
);
    localparam int XW = CW + LW + RW + PW;
    localparam logic [PW-1:0] PMAX = '1;

    typedef struct packed {
        logic [PW-1:0] pend;
    } st_t;

    st_t           s_q, s_d;
    logic [XW-1:0] m_x, ahead_x;
    logic          short_f;

    always_comb begin
        m_x     = XW'(metric);
        ahead_x = XW'(s_q.pend) + XW'(pre_pred);
        case (mode)
            PM_ESTIMATE: short_f = (m_x <= XW'(rate));
            PM_PRECHECK: short_f = (ahead_x > m_x);
            default:     short_f = (m_x <= XW'(lat));
        endcase
        stall = acc_pred && !quiet && short_f;

        s_d = s_q;
        if (pre_pred && !acc_pred && s_q.pend != PMAX)
            s_d.pend = s_q.pend + PW'(1);
        else if (acc_pred && !pre_pred && s_q.pend != '0)
            s_d.pend = s_q.pend - PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_PEND_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend == '0 && acc_pred && !pre_pred) |=> (s_q.pend == '0)); // R8
    AST_PEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_pred && !acc_pred && s_q.pend != PMAX) |=> (s_q.pend == $past(s_q.pend) + PW'(1))); // R8
    AST_PEND_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_pred && acc_pred) |=> $stable(s_q.pend)); // R8
endmodule

// File: rtl/stream_port_buf.sv
module stream_port_buf
    import spb_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int LW    = 4,
    parameter int RW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_recv,
    input  logic [1:0]    cfg_mode,
    input  logic [LW-1:0] cfg_lat,
    input  logic [RW-1:0] cfg_rate,
    input  logic          cfg_nonblock,
    input  logic          acc_pred,
    input  logic [DW-1:0] acc_wdata,
    input  logic          pre_pred,
    output logic [DW-1:0] rd_data,
    output logic          rd_hit,
    output logic          stall_req,
    output logic          ch_out_valid,
    output logic [DW-1:0] ch_out_data,
    input  logic          ch_in_ready,
    input  logic          ch_in_valid,
    input  logic [DW-1:0] ch_in_data,
    output logic          ch_out_ready
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count;
    logic [DW-1:0] head, wdata;
    logic          push, pop, full, held, quiet;
    logic [CW-1:0] metric;

    always_comb begin
        full  = (count == CW'(DEPTH));
        held  = (count != '0);
        quiet = cfg_recv && cfg_nonblock;
        if (cfg_recv) begin
            push   = ch_in_valid && !full;
            pop    = acc_pred && held;
            wdata  = ch_in_data;
            metric = count;
        end else begin
            push   = acc_pred && !full;
            pop    = ch_in_ready && held;
            wdata  = acc_wdata;
            metric = CW'(DEPTH) - count;
        end
        ch_out_valid = !cfg_recv && held;
        ch_out_data  = head;
        ch_out_ready = cfg_recv && !full;
        rd_hit       = cfg_recv && held;
        rd_data      = rd_hit ? head : '0;
    end

    spb_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (wdata),
        .head  (head),
        .count (count)
    );

    spb_predict #(.CW(CW), .LW(LW), .RW(RW)) u_pred (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (pred_mode_e'(cfg_mode)),
        .lat      (cfg_lat),
        .rate     (cfg_rate),
        .metric   (metric),
        .pre_pred (pre_pred),
        .acc_pred (acc_pred),
        .quiet    (quiet),
        .stall    (stall_req)
    );

    AST_STALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_pred |-> !stall_req); // R5
    AST_NB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_recv && cfg_nonblock) |-> !stall_req); // R9
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_recv && ch_out_valid && !ch_in_ready) |=> (ch_out_valid && $stable(ch_out_data))); // R2
    AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_recv && !ch_out_ready && !acc_pred) |=> !ch_out_ready); // R3
endmodule

// File: tb/stream_port_buf_test.sv
module stream_port_buf_test;
    localparam int D    = 16;
    localparam int PMAX = 63;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_recv = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [3:0]  cfg_lat = 4'd0;
    logic [4:0]  cfg_rate = 5'd0;
    logic        cfg_nonblock = 1'b0;
    logic        acc_pred = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic        pre_pred = 1'b0;
    logic [31:0] rd_data;
    logic        rd_hit;
    logic        stall_req;
    logic        ch_out_valid;
    logic [31:0] ch_out_data;
    logic        ch_in_ready = 1'b0;
    logic        ch_in_valid = 1'b0;
    logic [31:0] ch_in_data = '0;
    logic        ch_out_ready;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mq[$];
    int pend = 0;

    stream_port_buf uut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tg, what, act, exp);
        end
    endtask

    function automatic logic exp_stall(input logic ap, input logic pp);
        int  m;
        logic s;
        m = cfg_recv ? mq.size() : D - mq.size();
        case (cfg_mode)
            2'd1:    s = (m <= int'(cfg_rate));
            2'd2:    s = ((pend + int'(pp)) > m);
            default: s = (m <= int'(cfg_lat));
        endcase
        if (!ap) return 1'b0;
        if (cfg_recv && cfg_nonblock) return 1'b0;
        return s;
    endfunction

    function automatic string stall_tag(input logic ap);
        if (!ap) return "R5";
        if (cfg_recv && cfg_nonblock) return "R9";
        case (cfg_mode)
            2'd1:    return "R7";
            2'd2:    return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic apply_reset(input logic rcv, input logic [1:0] md, input logic [3:0] lt,
                               input logic [4:0] rt, input logic nb);
        @(negedge clk);
        rst_n = 1'b0;
        acc_pred = 0; pre_pred = 0; ch_in_ready = 0; ch_in_valid = 0;
        cfg_recv = rcv; cfg_mode = md; cfg_lat = lt; cfg_rate = rt; cfg_nonblock = nb;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mq.delete();
        pend = 0;
    endtask

    task automatic step(input logic ap, input logic [31:0] wd, input logic pp, input logic rdy,
                        input logic iv, input logic [31:0] id, input string tg);
        logic do_push, do_pop;
        @(negedge clk);
        acc_pred = ap; acc_wdata = wd; pre_pred = pp;
        ch_in_ready = rdy; ch_in_valid = iv; ch_in_data = id;
        #1;
        chk(stall_tag(ap), "stall_req", 32'(stall_req), 32'(exp_stall(ap, pp)));
        if (!cfg_recv) begin
            chk(tg, "ch_out_valid", 32'(ch_out_valid), 32'(mq.size() != 0));
            if (mq.size() != 0) chk(tg, "ch_out_data", ch_out_data, mq[0]);
            do_push = ap && (mq.size() < D);
            do_pop  = rdy && (mq.size() != 0);
            if (do_pop) void'(mq.pop_front());
            if (do_push) mq.push_back(wd);
        end else begin
            chk(tg, "ch_out_ready", 32'(ch_out_ready), 32'(mq.size() < D));
            chk(cfg_nonblock ? "R9" : tg, "rd_hit", 32'(rd_hit), 32'(mq.size() != 0));
            chk(cfg_nonblock ? "R9" : tg, "rd_data", rd_data, (mq.size() != 0) ? mq[0] : 32'h0);
            do_push = iv && (mq.size() < D);
            do_pop  = ap && (mq.size() != 0);
            if (do_pop) void'(mq.pop_front());
            if (do_push) mq.push_back(id);
        end
        if (pp && !ap && pend != PMAX) pend++;
        else if (ap && !pp && pend != 0) pend--;
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7731));
        // R1: reset state in receive mode and send mode
        apply_reset(1'b1, 2'd2, 4'd3, 5'd2, 1'b0);
        #1;
        chk("R1", "rd_hit", 32'(rd_hit), 32'h0);
        chk("R1", "ch_out_ready", 32'(ch_out_ready), 32'h1);
        apply_reset(1'b0, 2'd2, 4'd3, 5'd2, 1'b0);
        #1;
        chk("R1", "ch_out_valid", 32'(ch_out_valid), 32'h0);
        chk("R1", "stall_req", 32'(stall_req), 32'h0);
        step(1'b1, 32'hA0, 1'b0, 1'b0, 1'b0, 0, "R1");

        // R6 and R10: fill send buffer with channel blocked, then overflow and drain
        apply_reset(1'b0, 2'd0, 4'd3, 5'd0, 1'b0);
        for (int i = 0; i < D + 2; i++) step(1'b1, 32'h100 + 32'(i), 1'b0, 1'b0, 1'b0, 0, "R10");
        for (int i = 0; i < D + 2; i++) step(1'b0, 0, 1'b0, 1'b1, 1'b0, 0, "R2");

        // R4: steady push and pop with two words held
        apply_reset(1'b0, 2'd0, 4'd0, 5'd0, 1'b0);
        step(1'b1, 32'h11, 1'b0, 1'b0, 1'b0, 0, "R4");
        step(1'b1, 32'h22, 1'b0, 1'b0, 1'b0, 0, "R4");
        for (int i = 0; i < 6; i++) step(1'b1, 32'h300 + 32'(i), 1'b0, 1'b1, 1'b0, 0, "R4");
        for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b0, 1'b1, 1'b0, 0, "R4");

        // R8: pending floor at zero, then announce and compare against free space 1
        apply_reset(1'b0, 2'd2, 4'd0, 5'd0, 1'b0);
        for (int i = 0; i < D - 1; i++) step(1'b1, 32'h500 + 32'(i), 1'b0, 1'b0, 1'b0, 0, "R8");
        step(1'b0, 0, 1'b1, 1'b0, 1'b0, 0, "R8");
        step(1'b1, 32'h5FF, 1'b0, 1'b1, 1'b0, 0, "R8");
        step(1'b1, 32'h5FE, 1'b1, 1'b1, 1'b0, 0, "R8");
        step(1'b1, 32'h5FD, 1'b1, 1'b1, 1'b0, 0, "R8");

        // R3 and R10: receive fills, overflow dropped, read past empty
        apply_reset(1'b1, 2'd0, 4'd2, 5'd0, 1'b0);
        for (int i = 0; i < D + 2; i++) step(1'b0, 0, 1'b0, 1'b0, 1'b1, 32'h700 + 32'(i), "R3");
        for (int i = 0; i < D + 2; i++) step(1'b1, 0, 1'b0, 1'b0, 1'b0, 0, "R10");

        // Random phases over every mode and direction, plus non-blocking reads
        for (int ph = 0; ph < 7; ph++) begin
            logic rcv;
            logic [1:0] md;
            rcv = (ph >= 3);
            md  = 2'(ph % 3);
            if (ph == 6) md = 2'd0;
            apply_reset(rcv, md, 4'($urandom_range(9, 0)), 5'($urandom_range(16, 0)), ph == 6);
            for (int c = 0; c < 400; c++) begin
                step(1'($urandom_range(1, 0)), $urandom(), 1'($urandom_range(1, 0)),
                     1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), $urandom(),
                     rcv ? "R3" : "R2");
            end
        end
        finish_run();
    end
endmodule